// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block sequences one successive-approximation converter. It accepts start requests from four sources: a software single-shot bit, a software continuous-run bit, a timer overflow pulse, and an external active-low convert pin. It rejects a request while the converter is already busy, is powered off, or has no valid channel selected. Each accepted conversion runs through three phases, all counted in clock-enable ticks derived from the master clock: one synchronisation tick, a programmable track window, and a fixed hold window.

During the hold window the sequencer drives the sample/hold control and the channel number to an abstracted SAR core, and fires a start strobe. After the hold window it waits for the core's done flag. It then latches the 12-bit result with the channel tag, sets an interrupt flag and clears busy. A two-bit power mode decides whether the converter core and its reference are on all the time, only while converting, or never.

Top module: `adc_seq`

## Requirements
- R1: Power mode `cfg_mode` works as follows. 00 drives `core_pwr` and `ref_pwr` low and starts no conversion. 01 drives both high. 10 drives both equal to `busy`. 11 holds `ref_pwr` high and drives `core_pwr` equal to `busy`.
- R2: A conversion keeps `busy` high for exactly (16 + A) x D + 1 master-clock cycles. D = 2^`cfg_div` (1, 2, 4 or 8) and A = 2^`cfg_acq` (1, 2, 4 or 8). The ADC clock counts as 1 sync + A track + 15 hold ticks, and the extra master cycle collects the done flag.
- R3: A one-cycle pulse on `sw_single` sets `single_pend`. The pending bit starts one conversion once the block can accept it, and clears when that conversion completes.
- R4: While `cfg_cont` is high, a new conversion starts so that `busy` stays low for exactly one cycle between conversions.
- R5: A one-cycle `tmr_ovf` pulse while idle starts a conversion when `cfg_tmr_en` is 1, with `busy` high in the next cycle. With `cfg_tmr_en` at 0 it has no effect.
- R6: With `cfg_ext_en` at 1, a low-to-high transition on `ext_cnv_n` starts a conversion, after a two-flop synchroniser and edge detector. Holding the pin low starts nothing. With `cfg_ext_en` at 0 the pin has no effect.
- R7: `cfg_chan` codes 0000 to 0111 select inputs 0 to 7, and 1000 selects the temperature sensor. Code 1111 (stop) and the reserved codes 1001 to 1110 start no conversion.
- R8: `res_hi` holds the 4-bit channel code in bits 7:4 and result bits 11:8 in bits 3:0. `res_lo` holds result bits 7:0. Both reset to zero.
- R9: `busy` is high from the cycle after acceptance until completion. Any trigger that arrives while busy is ignored and is not queued.
- R10: `irq` sets when a conversion completes and clears on `irq_ack`. If both happen in the same cycle, the set wins.
- R11: `sar_start` is a one-cycle strobe issued on the first cycle of the hold phase. `sar_hold` is high from then until completion. `sar_chan` carries the accepted channel. The result is taken only after 15 ADC-clock ticks of hold, and only when `sar_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Power mode |
| cfg_div | input | 2 | ADC clock divide code |
| cfg_acq | input | 2 | Track window code |
| cfg_chan | input | 4 | Channel select code |
| cfg_cont | input | 1 | Continuous conversion enable |
| cfg_tmr_en | input | 1 | Timer trigger enable |
| cfg_ext_en | input | 1 | External pin trigger enable |
| sw_single | input | 1 | Write pulse that sets the single-shot bit |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_cnv_n | input | 1 | Asynchronous active-low convert pin |
| irq_ack | input | 1 | Interrupt acknowledge |
| sar_result | input | 12 | Result from the SAR core |
| sar_done | input | 1 | SAR core result-valid flag |
| sar_start | output | 1 | Start strobe to the SAR core |
| sar_hold | output | 1 | Sample/hold control, high = hold |
| sar_chan | output | 4 | Channel routed to the input multiplexer |
| busy | output | 1 | Conversion in progress |
| single_pend | output | 1 | Single-shot bit readback |
| irq | output | 1 | Conversion-complete interrupt flag |
| res_hi | output | 8 | Channel tag and result bits 11:8 |
| res_lo | output | 8 | Result bits 7:0 |
| core_pwr | output | 1 | Converter core power enable |
| ref_pwr | output | 1 | Reference power enable |

## Verification
A miscounted phase counter or a wrong divider limit shows directly in the length of `busy`. The bench measures that length exactly for each divide and track setting, so an error of one tick shows as D master cycles of difference as soon as that conversion ends. A wrong start gate shows within a few cycles: either `busy` rises when it should stay low, or it stays low when it should rise. A channel latched at the wrong time shows in the `res_hi` tag and on `sar_chan` at the start strobe. The interrupt and single-shot bits are read at the ports on the first idle cycle after each conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W     = 12;
    localparam int CH_W      = 4;
    localparam int HOLD_CLKS = 15;
    localparam int LAST_CH   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_TRACK,
        ST_HOLD,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        PM_OFF     = 2'b00,
        PM_NORMAL  = 2'b01,
        PM_BURST   = 2'b10,
        PM_STANDBY = 2'b11
    } pwr_mode_t;

    typedef struct packed {
        logic [CH_W-1:0]  tag;
        logic [RES_W-1:0] data;
    } tagged_res_t;

    // 2^code - 1 for a 2-bit code: terminal count of a 1/2/4/8 window
    function automatic logic [3:0] pow2_last(input logic [1:0] code);
        return (4'd1 << code) - 4'd1;
    endfunction

    function automatic logic chan_ok(input logic [CH_W-1:0] c);
        return c <= CH_W'(LAST_CH);
    endfunction

endpackage

// File: rtl/adc_clk_en.sv
module adc_clk_en
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [1:0] div_code,
    output logic       tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = DIV_W'(pow2_last(div_code));
    assign tick = (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
#(
    parameter int SYNC_N = 2,
    parameter int CHW    = CH_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           idle,
    input  logic [1:0]     mode,
    input  logic [CHW-1:0] chan,
    input  logic           single_pend,
    input  logic           cont,
    input  logic           tmr_en,
    input  logic           tmr_ovf,
    input  logic           ext_en,
    input  logic           ext_n,
    output logic           accept
);

    logic [SYNC_N-1:0] sync_q;
    logic              ext_prev;
    logic              ext_rise;
    logic              src_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            ext_prev <= 1'b1;
        end else begin
            sync_q   <= {sync_q[SYNC_N-2:0], ext_n};
            ext_prev <= sync_q[SYNC_N-1];
        end
    end

    assign ext_rise = sync_q[SYNC_N-1] & ~ext_prev;
    assign src_any  = single_pend | cont | (tmr_en & tmr_ovf) | (ext_en & ext_rise);
    assign accept   = idle & (mode != PM_OFF) & chan_ok(chan) & src_any;

endmodule

// File: rtl/adc_phase_ctl.sv
module adc_phase_ctl
    import adc_seq_pkg::*;
#(
    parameter int HOLD_N = HOLD_CLKS,
    parameter int CHW    = CH_W,
    parameter int CNT_W  = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  logic           tick,
    input  logic [1:0]     acq_code,
    input  logic [CHW-1:0] chan_in,
    input  logic           sar_done,
    output logic           busy,
    output logic           sar_start,
    output logic           sar_hold,
    output logic [CHW-1:0] chan_q,
    output logic           complete
);

    seq_state_t       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] acq_last;

    assign acq_last = CNT_W'(pow2_last(acq_code));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            sar_start <= 1'b0;
            chan_q    <= '0;
        end else begin
            sar_start <= 1'b0;
            case (st)
                ST_IDLE: if (accept) begin
                    st     <= ST_SYNC;
                    chan_q <= chan_in;
                end
                ST_SYNC: if (tick) begin
                    st  <= ST_TRACK;
                    cnt <= '0;
                end
                ST_TRACK: if (tick) begin
                    if (cnt == acq_last) begin
                        st        <= ST_HOLD;
                        cnt       <= '0;
                        sar_start <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: if (tick) begin
                    if (cnt == CNT_W'(HOLD_N - 1)) begin
                        st <= ST_FINISH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FINISH: if (sar_done) begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign sar_hold = (st == ST_HOLD) || (st == ST_FINISH);
    assign complete = (st == ST_FINISH) && sar_done;

    assert_start_in_hold_R11: assert property (@(posedge clk) disable iff (rst)
        sar_start |-> sar_hold);

    assert_start_single_R11: assert property (@(posedge clk) disable iff (rst)
        sar_start |=> !sar_start);

    assert_valid_chan_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (chan_q <= CHW'(LAST_CH)));

endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int RW     = RES_W,
    parameter int CHW    = CH_W,
    parameter int SYNC_N = 2,
    parameter int DIV_W  = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     cfg_mode,
    input  logic [1:0]     cfg_div,
    input  logic [1:0]     cfg_acq,
    input  logic [CHW-1:0] cfg_chan,
    input  logic           cfg_cont,
    input  logic           cfg_tmr_en,
    input  logic           cfg_ext_en,
    input  logic           sw_single,
    input  logic           tmr_ovf,
    input  logic           ext_cnv_n,
    input  logic           irq_ack,
    input  logic [RW-1:0]  sar_result,
    input  logic           sar_done,
    output logic           sar_start,
    output logic           sar_hold,
    output logic [CHW-1:0] sar_chan,
    output logic           busy,
    output logic           single_pend,
    output logic           irq,
    output logic [7:0]     res_hi,
    output logic [7:0]     res_lo,
    output logic           core_pwr,
    output logic           ref_pwr
);

    logic        accept;
    logic        tick;
    logic        complete;
    tagged_res_t res_q;

    adc_trig_sel #(.SYNC_N(SYNC_N), .CHW(CHW)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .idle       (!busy),
        .mode       (cfg_mode),
        .chan       (cfg_chan),
        .single_pend(single_pend),
        .cont       (cfg_cont),
        .tmr_en     (cfg_tmr_en),
        .tmr_ovf    (tmr_ovf),
        .ext_en     (cfg_ext_en),
        .ext_n      (ext_cnv_n),
        .accept     (accept)
    );

    adc_clk_en #(.DIV_W(DIV_W)) u_clk_en (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .div_code(cfg_div),
        .tick    (tick)
    );

    adc_phase_ctl #(.CHW(CHW)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .tick     (tick),
        .acq_code (cfg_acq),
        .chan_in  (cfg_chan),
        .sar_done (sar_done),
        .busy     (busy),
        .sar_start(sar_start),
        .sar_hold (sar_hold),
        .chan_q   (sar_chan),
        .complete (complete)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            single_pend <= 1'b0;
            irq         <= 1'b0;
            res_q       <= '0;
        end else begin
            if (sw_single) begin
                single_pend <= 1'b1;
            end else if (complete) begin
                single_pend <= 1'b0;
            end
            if (complete) begin
                irq <= 1'b1;
            end else if (irq_ack) begin
                irq <= 1'b0;
            end
            if (complete) begin
                res_q.tag  <= sar_chan;
                res_q.data <= sar_result;
            end
        end
    end

    assign res_hi = {res_q.tag, res_q.data[11:8]};
    assign res_lo = res_q.data[7:0];

    always_comb begin
        case (pwr_mode_t'(cfg_mode))
            PM_OFF:     begin core_pwr = 1'b0; ref_pwr = 1'b0; end
            PM_NORMAL:  begin core_pwr = 1'b1; ref_pwr = 1'b1; end
            PM_BURST:   begin core_pwr = busy; ref_pwr = busy; end
            default:    begin core_pwr = busy; ref_pwr = 1'b1; end
        endcase
    end

    assert_core_needs_ref_R1: assert property (@(posedge clk) disable iff (rst)
        core_pwr |-> ref_pwr);

    assert_off_no_start_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_mode == 2'b00) |=> !busy);

    assert_irq_on_done_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    assert_tag_on_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (res_hi[7:4] == sar_chan));

endmodule

// File: tb/adc_seq_tb.sv
`timescale 1ns/1ps
module adc_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_mode, cfg_div, cfg_acq;
    logic [3:0]  cfg_chan;
    logic        cfg_cont, cfg_tmr_en, cfg_ext_en;
    logic        sw_single, tmr_ovf, ext_cnv_n, irq_ack;
    logic [11:0] sar_result;
    logic        sar_done, sar_pend;
    logic        sar_start, sar_hold;
    logic [3:0]  sar_chan;
    logic        busy, single_pend, irq;
    logic [7:0]  res_hi, res_lo;
    logic        core_pwr, ref_pwr;

    int total = 0;
    int fails = 0;
    int starts = 0;
    logic       start_hold_ok = 1'b0;
    logic [3:0] start_chan = 4'd0;

    // div[7:6] acq[5:4] chan[3:0]
    localparam logic [7:0] VEC [0:5] = '{
        {2'd0, 2'd0, 4'd0},
        {2'd1, 2'd0, 4'd7},
        {2'd0, 2'd3, 4'd8},
        {2'd3, 2'd2, 4'd2},
        {2'd2, 2'd1, 4'd5},
        {2'd3, 2'd3, 4'd1}
    };

    always #2 clk = ~clk;

    adc_seq u_dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_div(cfg_div),
        .cfg_acq(cfg_acq), .cfg_chan(cfg_chan), .cfg_cont(cfg_cont),
        .cfg_tmr_en(cfg_tmr_en), .cfg_ext_en(cfg_ext_en), .sw_single(sw_single),
        .tmr_ovf(tmr_ovf), .ext_cnv_n(ext_cnv_n), .irq_ack(irq_ack),
        .sar_result(sar_result), .sar_done(sar_done), .sar_start(sar_start),
        .sar_hold(sar_hold), .sar_chan(sar_chan), .busy(busy),
        .single_pend(single_pend), .irq(irq), .res_hi(res_hi), .res_lo(res_lo),
        .core_pwr(core_pwr), .ref_pwr(ref_pwr)
    );

    function automatic logic [11:0] model_val(input logic [3:0] ch);
        return 12'hA53 ^ {ch, ch, ch};
    endfunction

    // behavioural SAR core
    always_ff @(posedge clk) begin
        if (rst) begin
            sar_done <= 1'b0; sar_pend <= 1'b0; sar_result <= '0;
        end else if (sar_start) begin
            sar_done <= 1'b0; sar_pend <= 1'b1; sar_result <= model_val(sar_chan);
        end else if (sar_pend) begin
            sar_done <= 1'b1; sar_pend <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (sar_start) begin
            starts        <= starts + 1;
            start_hold_ok <= sar_hold;
            start_chan    <= sar_chan;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_single();
        @(negedge clk) sw_single = 1'b1;
        @(negedge clk) sw_single = 1'b0;
    endtask

    task automatic wait_rise(input int n, output bit got);
        got = 1'b0;
        for (int i = 0; i < n && !got; i++) begin
            if (busy) got = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic wait_fall(output int len);
        len = 0;
        while (busy && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic idle_for(input int n, output bit saw);
        saw = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (busy) saw = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        bit got, saw;
        int len, gap, s0;
        rst = 1'b1; cfg_mode = 2'b00; cfg_div = 2'd0; cfg_acq = 2'd0; cfg_chan = 4'd0;
        cfg_cont = 1'b0; cfg_tmr_en = 1'b0; cfg_ext_en = 1'b0; sw_single = 1'b0;
        tmr_ovf = 1'b0; ext_cnv_n = 1'b1; irq_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        chk(!busy, "R9 reset busy", busy, 0);
        chk(!irq, "R10 reset irq", irq, 0);
        chk(res_hi == 8'h00 && res_lo == 8'h00, "R8 reset result", {res_hi, res_lo}, 0);
        chk(!core_pwr && !ref_pwr, "R1 mode00 power", {core_pwr, ref_pwr}, 0);

        // R1/R3: mode 00 holds off a pending single shot
        pulse_single();
        chk(single_pend, "R3 pending set", single_pend, 1);
        idle_for(30, saw);
        chk(!saw, "R1 mode00 no start", saw, 0);
        @(negedge clk) cfg_mode = 2'b01;
        #0;
        chk(core_pwr && ref_pwr, "R1 mode01 power", {core_pwr, ref_pwr}, 3);
        wait_rise(5, got);
        chk(got, "R3 pending starts", got, 1);
        wait_fall(len);
        chk(!single_pend, "R3 pending clears", single_pend, 0);

        // vector table: timing, packing, irq, SAR interface
        foreach (VEC[i]) begin
            cfg_div = VEC[i][7:6]; cfg_acq = VEC[i][5:4]; cfg_chan = VEC[i][3:0];
            @(negedge clk) irq_ack = 1'b1;
            @(negedge clk) irq_ack = 1'b0;
            s0 = starts;
            pulse_single();
            wait_rise(5, got);
            wait_fall(len);
            chk(len == (16 + (1 << VEC[i][5:4])) * (1 << VEC[i][7:6]) + 1,
                "R2 busy length", len, (16 + (1 << VEC[i][5:4])) * (1 << VEC[i][7:6]) + 1);
            chk(res_hi == {VEC[i][3:0], model_val(VEC[i][3:0])[11:8]}, "R8 res_hi",
                res_hi, {VEC[i][3:0], model_val(VEC[i][3:0])[11:8]});
            chk(res_lo == model_val(VEC[i][3:0])[7:0], "R8 res_lo",
                res_lo, model_val(VEC[i][3:0])[7:0]);
            chk(irq, "R10 irq set", irq, 1);
            chk(!single_pend, "R3 self clear", single_pend, 0);
            chk(starts - s0 == 1, "R11 one start", starts - s0, 1);
            chk(start_hold_ok, "R11 hold at start", start_hold_ok, 1);
            chk(start_chan == VEC[i][3:0], "R11 sar_chan", start_chan, VEC[i][3:0]);
        end

        // R10 ack clears, set wins over ack
        @(negedge clk) irq_ack = 1'b1;
        @(negedge clk) irq_ack = 1'b0;
        chk(!irq, "R10 ack clears", irq, 0);
        cfg_div = 2'd0; cfg_acq = 2'd0; cfg_chan = 4'd3;
        irq_ack = 1'b1;
        pulse_single();
        wait_rise(5, got);
        wait_fall(len);
        chk(irq, "R10 set beats ack", irq, 1);
        @(negedge clk) irq_ack = 1'b0;

        // R7 stop and reserved codes
        cfg_chan = 4'hF;
        pulse_single();
        idle_for(20, saw);
        chk(!saw, "R7 stop code", saw, 0);
        cfg_chan = 4'hA;
        idle_for(20, saw);
        chk(!saw, "R7 reserved code", saw, 0);
        cfg_chan = 4'd4;
        wait_rise(5, got);
        wait_fall(len);
        chk(res_hi[7:4] == 4'd4, "R7 valid after stop", res_hi[7:4], 4);

        // R5 timer trigger
        @(negedge clk) tmr_ovf = 1'b1;
        @(negedge clk) tmr_ovf = 1'b0;
        chk(!busy, "R5 timer disabled", busy, 0);
        idle_for(10, saw);
        chk(!saw, "R5 timer disabled idle", saw, 0);
        cfg_tmr_en = 1'b1;
        @(negedge clk) tmr_ovf = 1'b1;
        @(negedge clk) tmr_ovf = 1'b0;
        chk(busy, "R5 timer start", busy, 1);
        wait_fall(len);

        // R9 trigger during busy ignored
        pulse_single();
        wait_rise(5, got);
        repeat (5) @(negedge clk);
        tmr_ovf = 1'b1;
        @(negedge clk) tmr_ovf = 1'b0;
        wait_fall(len);
        idle_for(30, saw);
        chk(!saw, "R9 busy trigger dropped", saw, 0);
        cfg_tmr_en = 1'b0;

        // R6 external pin
        @(negedge clk) ext_cnv_n = 1'b0;
        idle_for(4, saw);
        ext_cnv_n = 1'b1;
        idle_for(6, got);
        chk(!saw && !got, "R6 disabled pin", {saw, got}, 0);
        cfg_ext_en = 1'b1;
        @(negedge clk) ext_cnv_n = 1'b0;
        idle_for(6, saw);
        chk(!saw, "R6 low level no start", saw, 0);
        ext_cnv_n = 1'b1;
        wait_rise(6, got);
        chk(got, "R6 rising edge start", got, 1);
        wait_fall(len);
        cfg_ext_en = 1'b0;

        // R4 continuous
        cfg_cont = 1'b1;
        wait_rise(5, got);
        wait_fall(len);
        gap = 0;
        while (!busy && gap < 20) begin gap++; @(negedge clk); end
        chk(gap == 1, "R4 one idle cycle", gap, 1);
        wait_fall(len);
        chk(len == 18, "R4 restart length", len, 18);
        cfg_cont = 1'b0;
        wait_rise(5, got);
        wait_fall(len);
        idle_for(30, saw);
        chk(!saw, "R4 stops when cleared", saw, 0);

        // R1 burst and standby modes
        cfg_mode = 2'b10;
        @(negedge clk);
        chk(!core_pwr && !ref_pwr, "R1 mode10 idle", {core_pwr, ref_pwr}, 0);
        pulse_single();
        wait_rise(5, got);
        chk(core_pwr && ref_pwr, "R1 mode10 busy", {core_pwr, ref_pwr}, 3);
        wait_fall(len);
        cfg_mode = 2'b11;
        @(negedge clk);
        chk(!core_pwr && ref_pwr, "R1 mode11 idle", {core_pwr, ref_pwr}, 1);
        pulse_single();
        wait_rise(5, got);
        chk(core_pwr && ref_pwr, "R1 mode11 busy", {core_pwr, ref_pwr}, 3);
        wait_fall(len);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule